// File: doc/BRIEF.md
# Buffered Serial Transmit Controller

This block is the digital controller on the sending side of a short-range pulse radio link. It runs on a 1 MHz system clock. User bytes are strobed into an eight-entry buffer. The controller shifts each byte out on a single data line and produces a matching bit clock, which the downstream analog modulation stage uses. The bit period is a parameter. Its default of ten system clocks gives a line rate of about 100 kb/s.

A mode input sets how the buffer is drained. In streaming mode every buffered byte is sent back to back until the buffer is empty. In single mode each accepted write strobe allows exactly one byte to go out, and the line then rests even if more bytes are waiting. A full flag tells the user that the buffer cannot take another byte. While the flag is high, write strobes are dropped.

Top module: `tx_link_ctrl`

## Requirements
- R1: During and after reset, and before any write, `full_flag`, `ser_data` and `bit_clk` are all 0.
- R2: `full_flag` is 1 exactly when the buffer holds 8 bytes, and 0 otherwise.
- R3: A write strobe seen while `full_flag` is 1 is dropped. That byte is never sent, and the bytes already held are sent unchanged.
- R4: Each byte is sent most significant bit first. Every bit is held unchanged on `ser_data` for BIT_CYCLES system clocks (default 10).
- R5: During each bit period, `bit_clk` is 1 for the first BIT_CYCLES/2 clocks (default 5) and 0 for the remaining clocks.
- R6: When no byte is in flight, `ser_data` and `bit_clk` both stay at 0.
- R7: With `stream_mode` = 1, buffered bytes go out in write order with no gap. The first bit of the next byte follows the last clock of the previous byte, and sending continues until the buffer is empty. No write strobe is needed.
- R8: With `stream_mode` = 0, each accepted write arms the sending of one byte. Several strobes accepted while already armed count as one. When a byte finishes and nothing is armed, the line goes idle even if bytes remain buffered.
- R9: If the line is idle and a write is accepted at clock edge k, the first bit of that byte appears on `ser_data` after edge k+1.
- R10: The mode is sampled when each byte starts. Switching to `stream_mode` = 1 while idle with bytes buffered starts sending without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (1 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one byte per clock |
| wr_data | input | WIDTH | Byte to buffer |
| stream_mode | input | 1 | 1 = stream the buffer, 0 = one byte per write |
| full_flag | output | 1 | Buffer full; writes are dropped |
| ser_data | output | 1 | Serial data bit, MSB first |
| bit_clk | output | 1 | Bit clock, high in the first half of each bit |

## Verification
The hardest state to reach is a full buffer. In streaming mode the first byte leaves the buffer one clock after it is written. The bench therefore holds the strobe for ten consecutive clocks. The ninth write fills the buffer while the first byte is on the line, and the tenth write meets a raised flag. A second difficult case is the single-mode arm collapsing. A three-write burst must produce exactly two back-to-back bytes and leave the third byte buffered. A later write then has to release that older byte, in order. An independent line decoder rebuilds every byte from the two outputs, including a sweep of all 256 byte values.

// File: rtl/tx_link_pkg.sv
package tx_link_pkg;

    typedef enum logic {
        SEND_SINGLE = 1'b0,
        SEND_STREAM = 1'b1
    } send_mode_e;

    // number of system clocks the bit clock stays high in one bit period
    function automatic int clk_high_cycles(input int bit_cycles);
        return (bit_cycles < 2) ? 1 : bit_cycles / 2;
    endfunction

endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             push_ok, pop_ok;

    always_comb begin
        push_ok = push && (st_q.cnt != FULL_CNT);
        pop_ok  = pop && (st_q.cnt != '0);
        st_d    = st_q;
        if (push_ok) begin
            st_d.wptr = (st_q.wptr == LAST_IDX) ? '0 : st_q.wptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rptr = (st_q.rptr == LAST_IDX) ? '0 : st_q.rptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wptr] <= push_data;
    end

    assign head  = mem_q[st_q.rptr];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == FULL_CNT);

    // R3: a full buffer stays full until something is taken out
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    // R2: occupancy moves by at most one per clock and never exceeds the depth
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.cnt == $past(st_q.cnt)) ||
                  (st_q.cnt == $past(st_q.cnt) + CW'(1)) ||
                  (st_q.cnt == $past(st_q.cnt) - CW'(1))));

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int BIT_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic bit_end,
    output logic clk_hi
);
    localparam int CW   = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam int HIGH = tx_link_pkg::clk_high_cycles(BIT_CYCLES);
    localparam logic [CW-1:0] LAST   = CW'(BIT_CYCLES - 1);
    localparam logic [CW-1:0] HIGH_C = CW'(HIGH);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_end = run && (st_q.cnt == LAST);
    assign clk_hi  = run && (st_q.cnt < HIGH_C);

    // R5: a byte that starts at a bit boundary opens with the bit clock high
    p_restart_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bit_end) |=> clk_hi);

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             bit_end,
    output logic             busy,
    output logic             ser_bit,
    output logic             last_end
);
    localparam int BW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [WIDTH-1:0] sh;
        logic [BW-1:0]    left;
        logic             busy;
    } sh_st_t;

    sh_st_t st_d, st_q;

    assign last_end = st_q.busy && bit_end && (st_q.left == BW'(1));

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh   = load_data;
            st_d.left = BW'(WIDTH);
            st_d.busy = 1'b1;
        end else if (st_q.busy && bit_end) begin
            st_d.sh   = {st_q.sh[WIDTH-2:0], 1'b0};
            st_d.left = st_q.left - 1'b1;
            if (last_end) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign ser_bit = st_q.busy & st_q.sh[WIDTH-1];

    // R4: the line does not move inside a bit period
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_end && !load) |=> $stable(ser_bit));

    // R9: a load always puts a byte in flight on the next clock
    p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

endmodule

// File: rtl/tx_link_ctrl.sv
module tx_link_ctrl
    import tx_link_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int DEPTH      = 8,
    parameter int BIT_CYCLES = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             stream_mode,
    output logic             full_flag,
    output logic             ser_data,
    output logic             bit_clk
);
    typedef struct packed {
        logic armed;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    send_mode_e       mode;
    logic             fifo_empty, fifo_full;
    logic [WIDTH-1:0] fifo_head;
    logic             sh_busy, sh_last, ser_bit;
    logic             bit_end, clk_hi;
    logic             wr_taken, slot_free, want_send, load;

    assign mode = stream_mode ? SEND_STREAM : SEND_SINGLE;

    always_comb begin
        wr_taken  = wr_en && !fifo_full;
        slot_free = !sh_busy || sh_last;
        want_send = !fifo_empty && ((mode == SEND_STREAM) || st_q.armed);
        load      = slot_free && want_send;
        st_d      = st_q;
        if (wr_taken)  st_d.armed = 1'b1;
        else if (load) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tx_byte_fifo #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (load),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    tx_bit_timer #(
        .BIT_CYCLES (BIT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (load),
        .run     (sh_busy),
        .bit_end (bit_end),
        .clk_hi  (clk_hi)
    );

    tx_shifter #(
        .WIDTH (WIDTH)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (fifo_head),
        .bit_end   (bit_end),
        .busy      (sh_busy),
        .ser_bit   (ser_bit),
        .last_end  (sh_last)
    );

    assign full_flag = fifo_full;
    assign ser_data  = ser_bit;
    assign bit_clk   = clk_hi;

    // R8: in single mode, a finished byte with nothing armed leaves the line idle
    p_single_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_last && !stream_mode && !st_q.armed) |=> (!bit_clk && !ser_data));

    // R7: in streaming mode a waiting byte follows with no idle clock
    p_stream_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_last && stream_mode && !fifo_empty) |=> bit_clk);

    // R6: nothing in flight means a quiet line
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> (!bit_clk && !ser_data));

endmodule

// File: tb/tb_tx_link_ctrl.sv
module tb_tx_link_ctrl;
    localparam int BITC = 10;
    localparam int HALF = 5;
    localparam int BYTE_CYC = 8 * BITC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       stream_mode = 1'b0;
    logic       full_flag, ser_data, bit_clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    logic [7:0] rx_bytes [512];
    int         rx_start [512];
    int         rx_n = 0;

    tx_link_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .stream_mode (stream_mode),
        .full_flag   (full_flag),
        .ser_data    (ser_data),
        .bit_clk     (bit_clk)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // independent line decoder
    bit         inb = 1'b0;
    int         phase = 0;
    int         nbit = 0;
    int         bstart = 0;
    logic       cur = 1'b0;
    logic [7:0] shr = '0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (!inb) begin
                if (bit_clk) begin
                    inb = 1'b1; phase = 0; nbit = 0; bstart = cyc;
                end else begin
                    chk(ser_data == 1'b0, "R6 idle ser_data", int'(ser_data), 0);
                end
            end
            if (inb) begin
                chk(bit_clk == (phase < HALF), "R5 bit_clk shape", int'(bit_clk), int'(phase < HALF));
                if (phase == 0) cur = ser_data;
                else chk(ser_data == cur, "R4 bit held", int'(ser_data), int'(cur));
                phase++;
                if (phase == BITC) begin
                    shr = {shr[6:0], cur};
                    phase = 0;
                    nbit++;
                    if (nbit == 8) begin
                        rx_bytes[rx_n] = shr;
                        rx_start[rx_n] = bstart;
                        rx_n++;
                        inb = 1'b0;
                    end
                end
            end
        end
    end

    task automatic push(input logic [7:0] v, output int at);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        at = cyc;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int at;
        int k0;
        int base;
        int v;
        idle(3);
        // R1 reset state
        chk(full_flag == 1'b0, "R1 full in reset", int'(full_flag), 0);
        chk(ser_data == 1'b0, "R1 ser in reset", int'(ser_data), 0);
        chk(bit_clk == 1'b0, "R1 clk in reset", int'(bit_clk), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        idle(5);
        chk(full_flag == 1'b0, "R1 full after reset", int'(full_flag), 0);
        chk(bit_clk == 1'b0, "R1 clk after reset", int'(bit_clk), 0);

        // single byte, latency and bit order (R4, R9)
        push(8'hA5, at);
        idle(100);
        chk(rx_n == 1, "R8 one byte sent", rx_n, 1);
        chk(rx_bytes[0] == 8'hA5, "R4 msb first", int'(rx_bytes[0]), 'hA5);
        chk(rx_start[0] == at + 1, "R9 start latency", rx_start[0], at + 1);

        // single mode: three strobes collapse into two sends (R8)
        base = rx_n;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h3C;
        @(negedge clk); k0 = cyc; wr_data = 8'hC3;
        @(negedge clk); wr_data = 8'h81;
        @(negedge clk); wr_en = 1'b0;
        idle(250);
        chk(rx_n == base + 2, "R8 armed count", rx_n - base, 2);
        chk(rx_bytes[base] == 8'h3C, "R8 first byte", int'(rx_bytes[base]), 'h3C);
        chk(rx_start[base] == k0 + 1, "R9 burst latency", rx_start[base], k0 + 1);
        chk(rx_bytes[base+1] == 8'hC3, "R8 second byte", int'(rx_bytes[base+1]), 'hC3);
        chk(rx_start[base+1] - rx_start[base] == BYTE_CYC, "R8 armed gapless",
            rx_start[base+1] - rx_start[base], BYTE_CYC);
        // new write releases the older buffered byte
        push(8'h5A, at);
        idle(100);
        chk(rx_n == base + 3, "R8 release count", rx_n - base, 3);
        chk(rx_bytes[base+2] == 8'h81, "R8 fifo order", int'(rx_bytes[base+2]), 'h81);
        chk(rx_start[base+2] == at + 1, "R9 release latency", rx_start[base+2], at + 1);
        // switching to stream sends the waiting byte with no write (R10)
        @(negedge clk); stream_mode = 1'b1;
        idle(100);
        chk(rx_n == base + 4, "R10 mode switch send", rx_n - base, 4);
        chk(rx_bytes[base+3] == 8'h5A, "R10 byte value", int'(rx_bytes[base+3]), 'h5A);

        // stream fill: ten strobes, ninth fills, tenth dropped (R2, R3, R7)
        base = rx_n;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k > 0) chk(full_flag == (k >= 9), "R2 full during fill", int'(full_flag), int'(k >= 9));
            wr_en = 1'b1; wr_data = 8'(8'h10 + k);
        end
        @(negedge clk); wr_en = 1'b0;
        chk(full_flag == 1'b1, "R2 full after fill", int'(full_flag), 1);
        idle(60);
        chk(full_flag == 1'b1, "R3 still full", int'(full_flag), 1);
        idle(800);
        chk(full_flag == 1'b0, "R2 drained", int'(full_flag), 0);
        chk(rx_n == base + 9, "R3 dropped byte not sent", rx_n - base, 9);
        for (int i = 0; i < 9; i++) begin
            chk(rx_bytes[base+i] == 8'(8'h10 + i), "R7 stream order", int'(rx_bytes[base+i]), 'h10 + i);
            if (i > 0)
                chk(rx_start[base+i] - rx_start[base+i-1] == BYTE_CYC, "R7 no gap",
                    rx_start[base+i] - rx_start[base+i-1], BYTE_CYC);
        end

        // sweep of every byte value through the stream path
        base = rx_n;
        v = 0;
        while (v < 256) begin
            @(negedge clk);
            if (!full_flag) begin
                wr_en = 1'b1; wr_data = 8'(v); v++;
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk); wr_en = 1'b0;
        for (int i = 0; i < 30000 && rx_n < base + 256; i++) @(negedge clk);
        idle(20);
        chk(rx_n == base + 256, "R7 sweep count", rx_n - base, 256);
        for (int i = 0; i < 256; i++)
            chk(rx_bytes[base+i] == 8'(i), "R4 sweep value", int'(rx_bytes[base+i]), i);
        chk(full_flag == 1'b0 && bit_clk == 1'b0, "R6 idle at end", int'(bit_clk), 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule